// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Sequencer

This block turns one digital PWM command into two gate enables for a synchronous buck half-bridge. One enable drives the high-side switch and the other drives the low-side switch. The dead time between them is not a fixed count. Three digital comparator flags report the real state of the power stage: the low-side gate is low, the high-side gate-source voltage is low, and the switch node is low. Each turn-on waits for the flag that proves the opposite switch has really stopped conducting. The dead time therefore follows the actual switching speed of the transistors in use.

A rising PWM edge removes the low-side enable after a short propagation delay. A blanking interval then passes, and the high-side enable follows once the low-side gate is reported low. A falling PWM edge removes the high-side enable after the same propagation delay. The low-side enable then follows as soon as the switch node is reported low. If that flag never comes, the low-side enable follows a fixed fallback interval after the high-side gate-source is reported low.

A power-good input gates the whole sequence. While it is low, both enables are held off and PWM has no effect. All intervals are parameters counted in clock cycles. The defaults suit a 1 GHz clock: 10 cycles of propagation delay, 25 cycles of blanking and 40 cycles of fallback. Every interval parameter must be at least 1.

Top module: `gate_sequencer`

## Requirements
- R1: While `rst_n` is low, `hs_en_o` and `ls_en_o` are both 0.
- R2: PWM rising while the low side is on: `pwm_i` is first sampled high at clock edge E. `ls_en_o` stays 1 through edge E+PROP_CYC-1 and falls to 0 at edge E+PROP_CYC.
- R3: `hs_en_o` and `ls_en_o` are never 1 in the same cycle.
- R4: After the low-side enable is removed, `lg_low_i` is ignored for BLANK_CYC cycles. If `lg_low_i` was already 1, `hs_en_o` rises one edge after the blanking ends. Otherwise `hs_en_o` stays 0 and rises at the first edge that samples `lg_low_i` = 1.
- R5: PWM falling while the high side is on: `pwm_i` is first sampled low at edge E. `hs_en_o` stays 1 through edge E+PROP_CYC-1 and falls to 0 at edge E+PROP_CYC.
- R6: While the sequencer waits to turn on the low side, `ls_en_o` rises at the first edge that samples `sw_low_i` = 1. It stays 0 while no flag is asserted.
- R7: Fallback. While waiting to turn on the low side with `sw_low_i` = 0, let E be the first edge that samples `ug_low_i` = 1. Then `ls_en_o` rises at edge E+FALLBACK_CYC.
- R8: Power-good. An edge that samples `pwr_ok_i` = 0 drives both enables to 0, and they stay 0 whatever `pwm_i` does. When `pwr_ok_i` returns to 1 with PWM low, the low-side sequence restarts from the off state. It passes through the same wait as in R6 and R7, so with only `ug_low_i` = 1 the first edge moves to the wait and `ls_en_o` rises FALLBACK_CYC edges after that.
- R9: Reversal. If PWM reverses while the low side is still on during its propagation delay, the low side stays on with no gap. If PWM reverses while both enables are off and the high-side turn-on is still pending, the high-side turn-on is dropped, and the low side is restored through the R6 and R7 wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM command (1 = high side on) |
| pwr_ok_i | input | 1 | Supply power-good flag |
| lg_low_i | input | 1 | Low-side gate is below its threshold |
| ug_low_i | input | 1 | High-side gate-source is below its threshold |
| sw_low_i | input | 1 | Switch node is below its threshold |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
Some properties are checked on every cycle. The two enables never overlap. Every rise of the high-side enable is preceded by a sampled low-side-gate-low flag. Every rise of the low-side enable is preceded by either a sampled switch-node-low flag or the end of the fallback count. An enable falls only after PWM moved away from it or power-good dropped. A low power-good forces both enables off.

The exact cycle counts of the propagation delay, blanking and fallback can only be shown by the bench's directed scenarios. The same holds for the choice between the switch-node flag and the fallback, the abandoning of a pending turn-on when PWM reverses, and the restart after power-good returns.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;
  typedef enum logic [3:0] {
    ST_OFF      = 4'd0,
    ST_LS_ON    = 4'd1,
    ST_HS_PROP  = 4'd2,
    ST_HS_BLANK = 4'd3,
    ST_HS_WAIT  = 4'd4,
    ST_HS_ON    = 4'd5,
    ST_LS_PROP  = 4'd6,
    ST_LS_WAIT  = 4'd7,
    ST_LS_FB    = 4'd8
  } seq_state_t;
endpackage

// File: rtl/gate_seq_timer.sv
module gate_seq_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load_i)              cnt_d = load_val_i;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/gate_seq_fsm.sv
module gate_seq_fsm
  import gate_seq_pkg::*;
#(
  parameter int unsigned CW           = 6,
  parameter int unsigned PROP_CYC     = 10,
  parameter int unsigned BLANK_CYC    = 25,
  parameter int unsigned FALLBACK_CYC = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_i,
  input  logic          pwr_ok_i,
  input  logic          lg_low_i,
  input  logic          ug_low_i,
  input  logic          sw_low_i,
  input  logic          tmr_done_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output seq_state_t    st_next_o
);
  localparam logic [CW-1:0] PROP_LD  = CW'(PROP_CYC - 1);
  localparam logic [CW-1:0] BLANK_LD = CW'(BLANK_CYC - 1);
  localparam logic [CW-1:0] FB_LD    = CW'(FALLBACK_CYC - 1);

  seq_state_t st_q, st_d;

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    case (st_q)
      ST_OFF: begin
        if (pwm_i) begin
          st_d = ST_HS_BLANK; tmr_load_o = 1'b1; tmr_val_o = BLANK_LD;
        end else begin
          st_d = ST_LS_WAIT;
        end
      end
      ST_LS_ON: begin
        if (pwm_i) begin
          st_d = ST_HS_PROP; tmr_load_o = 1'b1; tmr_val_o = PROP_LD;
        end
      end
      ST_HS_PROP: begin
        if (!pwm_i) st_d = ST_LS_ON;
        else if (tmr_done_i) begin
          st_d = ST_HS_BLANK; tmr_load_o = 1'b1; tmr_val_o = BLANK_LD;
        end
      end
      ST_HS_BLANK: begin
        if (!pwm_i)          st_d = ST_LS_WAIT;
        else if (tmr_done_i) st_d = ST_HS_WAIT;
      end
      ST_HS_WAIT: begin
        if (!pwm_i)        st_d = ST_LS_WAIT;
        else if (lg_low_i) st_d = ST_HS_ON;
      end
      ST_HS_ON: begin
        if (!pwm_i) begin
          st_d = ST_LS_PROP; tmr_load_o = 1'b1; tmr_val_o = PROP_LD;
        end
      end
      ST_LS_PROP: begin
        if (pwm_i)           st_d = ST_HS_ON;
        else if (tmr_done_i) st_d = ST_LS_WAIT;
      end
      ST_LS_WAIT: begin
        if (pwm_i) begin
          st_d = ST_HS_BLANK; tmr_load_o = 1'b1; tmr_val_o = BLANK_LD;
        end else if (sw_low_i) st_d = ST_LS_ON;
        else if (ug_low_i) begin
          st_d = ST_LS_FB; tmr_load_o = 1'b1; tmr_val_o = FB_LD;
        end
      end
      ST_LS_FB: begin
        if (pwm_i) begin
          st_d = ST_HS_BLANK; tmr_load_o = 1'b1; tmr_val_o = BLANK_LD;
        end else if (sw_low_i || tmr_done_i) st_d = ST_LS_ON;
      end
      default: st_d = ST_OFF;
    endcase
    if (!pwr_ok_i) begin
      st_d       = ST_OFF;
      tmr_load_o = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign st_next_o = st_d;

  // Low side may only come on from a switch-node flag or an expired fallback.
  assert_ls_on_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LS_ON) && ($past(st_q) inside {ST_LS_WAIT, ST_LS_FB}) |->
      $past(sw_low_i) || $past(tmr_done_i));

  // R7: a fallback never ends early without a switch-node flag.
  assert_fb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LS_FB) && !tmr_done_i && !sw_low_i && pwr_ok_i && !pwm_i
      |=> (st_q == ST_LS_FB));
endmodule

// File: rtl/gate_seq_outreg.sv
module gate_seq_outreg
  import gate_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_t st_next_i,
  output logic       hs_en_o,
  output logic       ls_en_o
);
  logic hs_d, ls_d, hs_q, ls_q;

  always_comb begin
    hs_d = (st_next_i == ST_HS_ON) || (st_next_i == ST_LS_PROP);
    ls_d = (st_next_i == ST_LS_ON) || (st_next_i == ST_HS_PROP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
    end
  end

  assign hs_en_o = hs_q;
  assign ls_en_o = ls_q;

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q));
endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
  import gate_seq_pkg::*;
#(
  parameter int unsigned PROP_CYC     = 10,
  parameter int unsigned BLANK_CYC    = 25,
  parameter int unsigned FALLBACK_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic pwr_ok_i,
  input  logic lg_low_i,
  input  logic ug_low_i,
  input  logic sw_low_i,
  output logic hs_en_o,
  output logic ls_en_o
);
  localparam int unsigned MAX_AB = (PROP_CYC > BLANK_CYC) ? PROP_CYC : BLANK_CYC;
  localparam int unsigned MAX_C  = (MAX_AB > FALLBACK_CYC) ? MAX_AB : FALLBACK_CYC;
  localparam int unsigned CW     = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  seq_state_t    st_next;

  gate_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .done_o(tmr_done)
  );

  gate_seq_fsm #(
    .CW(CW), .PROP_CYC(PROP_CYC), .BLANK_CYC(BLANK_CYC),
    .FALLBACK_CYC(FALLBACK_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm_i), .pwr_ok_i(pwr_ok_i),
    .lg_low_i(lg_low_i), .ug_low_i(ug_low_i), .sw_low_i(sw_low_i),
    .tmr_done_i(tmr_done), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .st_next_o(st_next)
  );

  gate_seq_outreg u_out (
    .clk(clk), .rst_n(rst_n), .st_next_i(st_next),
    .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
  );

  assert_pwr_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok_i |=> (!hs_en_o && !ls_en_o));

  assert_hs_needs_lg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en_o) |-> $past(lg_low_i));

  assert_hs_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_en_o) |-> ($past(!pwm_i) || $past(!pwr_ok_i)));

  assert_ls_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls_en_o) |-> ($past(pwm_i) || $past(!pwr_ok_i)));
endmodule

// File: tb/sim_gate_sequencer.sv
`timescale 1ns/1ps
module sim_gate_sequencer;
  localparam int PROP  = 3;
  localparam int BLANK = 5;
  localparam int FB    = 8;

  logic clk = 1'b0;
  logic rst_n, pwm, pwr_ok, lg_low, ug_low, sw_low;
  logic hs, ls;
  int checks = 0;
  int errors = 0;
  int overlap = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  gate_sequencer #(.PROP_CYC(PROP), .BLANK_CYC(BLANK), .FALLBACK_CYC(FB)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .pwr_ok_i(pwr_ok),
    .lg_low_i(lg_low), .ug_low_i(ug_low), .sw_low_i(sw_low),
    .hs_en_o(hs), .ls_en_o(ls)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n === 1'b1 && hs && ls) overlap <= overlap + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycles %0d expected below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pwm = 1'b0; pwr_ok = 1'b0;
    lg_low = 1'b0; ug_low = 1'b0; sw_low = 1'b0;
    wn(3);
    chk("R1 hs in reset", hs, 1'b0);
    chk("R1 ls in reset", ls, 1'b0);
    rst_n = 1'b1;
    pwm = 1'b1; wn(4);
    chk("R8 hs with power low", hs, 1'b0);
    pwm = 1'b0; ug_low = 1'b1; sw_low = 1'b1; wn(4);
    chk("R8 ls with power low", ls, 1'b0);
    sw_low = 1'b0; ug_low = 1'b0;
  endtask

  task automatic t_startup;
    pwm = 1'b0; ug_low = 1'b1; pwr_ok = 1'b1;
    wn(FB + 1);
    chk("R8 R7 ls before fallback", ls, 1'b0);
    wn(1);
    chk("R8 R7 ls after fallback", ls, 1'b1);
  endtask

  task automatic t_rise;
    ug_low = 1'b0; lg_low = 1'b0; pwm = 1'b1;
    wn(PROP);
    chk("R2 ls held during delay", ls, 1'b1);
    wn(1);
    chk("R2 ls removed", ls, 1'b0);
    chk("R4 hs off at ls removal", hs, 1'b0);
    lg_low = 1'b1;
    wn(BLANK);
    chk("R4 hs off through blanking", hs, 1'b0);
    wn(1);
    chk("R4 hs on after blanking", hs, 1'b1);
  endtask

  task automatic t_fall_sw;
    lg_low = 1'b0; ug_low = 1'b0; sw_low = 1'b0; pwm = 1'b0;
    wn(PROP);
    chk("R5 hs held during delay", hs, 1'b1);
    wn(1);
    chk("R5 hs removed", hs, 1'b0);
    wn(10);
    chk("R6 ls off without flags", ls, 1'b0);
    sw_low = 1'b1;
    wn(1);
    chk("R6 ls on after phase low", ls, 1'b1);
    sw_low = 1'b0;
  endtask

  task automatic t_rise_wait;
    lg_low = 1'b0; pwm = 1'b1;
    wn(PROP + BLANK + 11);
    chk("R4 hs waits for gate flag", hs, 1'b0);
    lg_low = 1'b1;
    wn(1);
    chk("R4 hs on after gate flag", hs, 1'b1);
  endtask

  task automatic t_fall_ug;
    lg_low = 1'b0; ug_low = 1'b0; sw_low = 1'b0; pwm = 1'b0;
    wn(PROP + 1);
    chk("R5 hs removed", hs, 1'b0);
    wn(3);
    chk("R7 ls off before flag", ls, 1'b0);
    ug_low = 1'b1;
    wn(FB);
    chk("R7 ls off during fallback", ls, 1'b0);
    wn(1);
    chk("R7 ls on after fallback", ls, 1'b1);
  endtask

  task automatic t_rev_prop;
    lg_low = 1'b0; pwm = 1'b1;
    wn(1);
    pwm = 1'b0;
    for (int i = 0; i < 2 * PROP + 2; i++) begin
      wn(1);
      chk("R9 ls kept on after reversal", ls, 1'b1);
    end
    chk("R9 hs off after reversal", hs, 1'b0);
  endtask

  task automatic t_rev_wait;
    ug_low = 1'b0; lg_low = 1'b0; pwm = 1'b1;
    wn(PROP + 2);
    chk("R9 ls removed before reversal", ls, 1'b0);
    pwm = 1'b0; ug_low = 1'b1;
    wn(1);
    chk("R9 hs dropped on reversal", hs, 1'b0);
    wn(FB);
    chk("R9 ls still off", ls, 1'b0);
    wn(1);
    chk("R9 ls restored", ls, 1'b1);
  endtask

  task automatic t_pwr_drop;
    lg_low = 1'b1; pwm = 1'b1;
    wn(PROP + BLANK + 2);
    chk("R4 hs on before power drop", hs, 1'b1);
    pwr_ok = 1'b0;
    wn(1);
    chk("R8 hs off on power drop", hs, 1'b0);
    chk("R8 ls off on power drop", ls, 1'b0);
    pwm = 1'b0; sw_low = 1'b1; wn(3);
    pwm = 1'b1; wn(3);
    chk("R8 hs ignores pwm", hs, 1'b0);
    chk("R8 ls ignores pwm", ls, 1'b0);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_rise();
    t_fall_sw();
    t_rev_prop();
    t_rise_wait();
    t_fall_ug();
    t_rev_wait();
    t_pwr_drop();
    wn(1);
    checks++;
    if (overlap != 0) begin
      errors++;
      $display("FAIL R3 overlap cycles: actual %0d expected 0", overlap);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule